// File: doc/BRIEF.md
# Call and Branch Control Unit

This block is the control slot of a pipelined wide-instruction processor and owns the program counter. In each cycle it takes the control fields of the instruction being executed: a 4-bit opcode, a 4-bit condition/destination field, a 4-bit base-register field and a displacement. It chooses one of three outcomes for the next fetch address. It can step to the next word, jump to a computed target, or call a computed target. A call also writes a return address into one of four link registers that belong to the unit.

Instruction fetch overlaps execution, so the program counter output is always one word ahead of the instruction being decoded. The word already fetched when a transfer is decoded is executed in the next cycle, which gives exactly one delay slot. The register file sits outside the block. The unit drives its two read indices and receives the condition operand and the base operand back as plain values.

Top module: `xfer_ctrl_unit`

## Requirements
- R1: While reset is asserted `fetch_pc` is 0. In the first cycle after reset is released, no transfer, link write or illegal flag is produced, whatever opcode is presented, and `fetch_pc` then becomes 1.
- R2: When no transfer is taken, `fetch_pc` advances by one in the next cycle, wrapping modulo 2^PC_W.
- R3: Opcode 4'b0001 always transfers. Any taken transfer loads `fetch_pc` with (`ctl_disp` + `base_val`) mod 2^PC_W in the next cycle, and `xfer_taken` is high in the deciding cycle.
- R4: Opcodes 4'b0010 to 4'b0111 transfer when `cond_val`, read as a two's-complement number, is respectively >0, <0, ==0, >=0, <=0, !=0. Otherwise they fall through.
- R5: Opcode 4'b0000 with `ctl_r[3:2]` = 2'b00 is a call. In that cycle `link_we` is high, `link_idx` equals `ctl_r[1:0]`, `link_data` equals the current `fetch_pc` + 1, and the transfer of R3 is taken.
- R6: A transfer takes effect on the fetch address one cycle after it is decoded. A transfer decoded in the following cycle (the delay slot) is itself obeyed, so its target replaces the first target.
- R7: Opcodes 4'b1000 to 4'b1111, and opcode 4'b0000 with `ctl_r[3:2]` not 2'b00, fall through with no link write and raise `illegal_op` for that cycle.
- R8: `cond_rd_idx` follows `ctl_r` and `base_rd_idx` follows `ctl_x` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_op | input | 4 | Control opcode of the executing instruction |
| ctl_r | input | 4 | Condition register index, or call extension and link index |
| ctl_x | input | 4 | Base register index for the target |
| ctl_disp | input | DISP_W | Target displacement |
| cond_rd_idx | output | 4 | Register file read index for the condition operand |
| base_rd_idx | output | 4 | Register file read index for the base operand |
| cond_val | input | DATA_W | Value of the register named by `ctl_r` |
| base_val | input | DATA_W | Value of the register named by `ctl_x` |
| fetch_pc | output | PC_W | Program counter, the address being fetched |
| xfer_taken | output | 1 | A transfer is taken this cycle |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 2 | Link register written by a call |
| link_data | output | PC_W | Return address written by a call |
| illegal_op | output | 1 | Undefined control opcode seen this cycle |

## Verification
A call does two things in one cycle. It writes the return address and it redirects the fetch address. The return address must be taken from the program counter before the redirect. The bench issues calls with different link indices and wrapping targets. It then checks that the link data equals the old fetch address plus one while the next fetch address equals the target. It also decodes two transfers back to back, so the delay-slot transfer lands in the cycle right after the first redirect, and it checks that the second target wins.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

   localparam int OP_W  = 4;
   localparam int IDX_W = 4;
   localparam int LNK_W = 2;

   typedef enum logic [OP_W-1:0] {
      OP_CALL = 4'b0000,
      OP_JMP  = 4'b0001,
      OP_BGT  = 4'b0010,
      OP_BLT  = 4'b0011,
      OP_BEQ  = 4'b0100,
      OP_BGE  = 4'b0101,
      OP_BLE  = 4'b0110,
      OP_BNE  = 4'b0111
   } ctl_op_e;

   typedef struct packed {
      logic is_call;
      logic is_jump;
      logic is_cond;
      logic is_bad;
   } ctl_kind_t;

endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
   import xfer_pkg::*;
(
   input  logic [OP_W-1:0]  op,
   input  logic [1:0]       r_ext,
   output ctl_kind_t        kind
);

   always_comb begin
      kind = '0;
      if (op[OP_W-1]) begin
         kind.is_bad = 1'b1;
      end else begin
         unique case (op)
            OP_CALL: begin
               if (r_ext == 2'b00) kind.is_call = 1'b1;
               else                kind.is_bad  = 1'b1;
            end
            OP_JMP:  kind.is_jump = 1'b1;
            default: kind.is_cond = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/xfer_cond.sv
module xfer_cond #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] value,
   output logic              hit
);

   logic neg;
   logic zero;

   assign neg  = value[DATA_W-1];
   assign zero = (value == '0);

   always_comb begin
      unique case (sel)
         3'd2:    hit = !neg && !zero;
         3'd3:    hit = neg;
         3'd4:    hit = zero;
         3'd5:    hit = !neg;
         3'd6:    hit = neg || zero;
         3'd7:    hit = !zero;
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/xfer_pc.sv
module xfer_pc #(
   parameter int PC_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc,
   output logic            live
);

   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc   <= '0;
         live <= 1'b0;
      end else begin
         live <= 1'b1;
         if (load) pc <= target;
         else      pc <= pc + STEP;
      end
   end

endmodule

// File: rtl/xfer_ctrl_unit.sv
module xfer_ctrl_unit
   import xfer_pkg::*;
#(
   parameter int PC_W   = 20,
   parameter int DISP_W = 20,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ctl_op,
   input  logic [3:0]        ctl_r,
   input  logic [3:0]        ctl_x,
   input  logic [DISP_W-1:0] ctl_disp,
   output logic [3:0]        cond_rd_idx,
   output logic [3:0]        base_rd_idx,
   input  logic [DATA_W-1:0] cond_val,
   input  logic [DATA_W-1:0] base_val,
   output logic [PC_W-1:0]   fetch_pc,
   output logic              xfer_taken,
   output logic              link_we,
   output logic [1:0]        link_idx,
   output logic [PC_W-1:0]   link_data,
   output logic              illegal_op
);

   localparam logic [PC_W-1:0] ONE = PC_W'(1);

   if (PC_W < 2 || PC_W > DATA_W) begin : g_bad_pc_w
      $error("xfer_ctrl_unit: PC_W must lie in 2..DATA_W");
   end
   if (DISP_W < 1 || DATA_W < 2) begin : g_bad_widths
      $error("xfer_ctrl_unit: DISP_W and DATA_W too small");
   end

   ctl_kind_t       kind;
   logic            cond_hit;
   logic            live;
   logic [PC_W-1:0] disp_t;
   logic [PC_W-1:0] base_t;
   logic [PC_W-1:0] target;

   // Width adaptation of the displacement into the PC space
   if (DISP_W >= PC_W) begin : g_disp_trunc
      assign disp_t = ctl_disp[PC_W-1:0];
   end else begin : g_disp_ext
      assign disp_t = {{(PC_W-DISP_W){1'b0}}, ctl_disp};
   end
   assign base_t = base_val[PC_W-1:0];
   assign target = disp_t + base_t;

   xfer_decode u_decode (
      .op    (ctl_op),
      .r_ext (ctl_r[3:2]),
      .kind  (kind)
   );

   xfer_cond #(.DATA_W(DATA_W)) u_cond (
      .sel   (ctl_op[2:0]),
      .value (cond_val),
      .hit   (cond_hit)
   );

   xfer_pc #(.PC_W(PC_W)) u_pc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (xfer_taken),
      .target (target),
      .pc     (fetch_pc),
      .live   (live)
   );

   assign cond_rd_idx = ctl_r;
   assign base_rd_idx = ctl_x;

   assign xfer_taken = live && (kind.is_jump || kind.is_call ||
                                (kind.is_cond && cond_hit));
   assign link_we    = live && kind.is_call;
   assign link_idx   = ctl_r[1:0];
   assign link_data  = fetch_pc + ONE;
   assign illegal_op = live && kind.is_bad;

endmodule

// File: rtl/xfer_ctrl_unit_chk.sv
module xfer_ctrl_unit_chk #(
   parameter int PC_W   = 20,
   parameter int DISP_W = 20,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        ctl_op,
   input logic [3:0]        ctl_r,
   input logic [DISP_W-1:0] ctl_disp,
   input logic [DATA_W-1:0] base_val,
   input logic [PC_W-1:0]   fetch_pc,
   input logic              xfer_taken,
   input logic              link_we,
   input logic [1:0]        link_idx,
   input logic [PC_W-1:0]   link_data,
   input logic              illegal_op
);

   always_ff @(posedge clk) begin
      if (!rst_n) assert_reset_pc_R1: assert (fetch_pc == '0);
   end

   assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_taken |=> fetch_pc == $past(fetch_pc) + PC_W'(1));

   assert_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_taken |=> fetch_pc == PC_W'($past(ctl_disp)) + PC_W'($past(base_val)));

   assert_call_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (xfer_taken && link_data == fetch_pc + PC_W'(1) &&
                   link_idx == ctl_r[1:0] && ctl_op == 4'b0000 && ctl_r[3:2] == 2'b00));

   assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (!xfer_taken && !link_we));

   assert_illegal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_op[3] && !illegal_op) |-> $past(!rst_n) || !$past(rst_n));

endmodule

bind xfer_ctrl_unit xfer_ctrl_unit_chk #(
   .PC_W(PC_W), .DISP_W(DISP_W), .DATA_W(DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_op     (ctl_op),
   .ctl_r      (ctl_r),
   .ctl_disp   (ctl_disp),
   .base_val   (base_val),
   .fetch_pc   (fetch_pc),
   .xfer_taken (xfer_taken),
   .link_we    (link_we),
   .link_idx   (link_idx),
   .link_data  (link_data),
   .illegal_op (illegal_op)
);

// File: tb/xfer_ctrl_unit_bench.sv
module xfer_ctrl_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W   = 20;
   localparam int DISP_W = 20;
   localparam int DATA_W = 32;
   localparam int NVEC   = 18;
   localparam logic [PC_W-1:0] PC_MASK = '1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [3:0]        ctl_op = 4'h0;
   logic [3:0]        ctl_r = 4'h0;
   logic [3:0]        ctl_x = 4'h0;
   logic [DISP_W-1:0] ctl_disp = '0;
   logic [3:0]        cond_rd_idx;
   logic [3:0]        base_rd_idx;
   logic [DATA_W-1:0] cond_val = '0;
   logic [DATA_W-1:0] base_val = '0;
   logic [PC_W-1:0]   fetch_pc;
   logic              xfer_taken;
   logic              link_we;
   logic [1:0]        link_idx;
   logic [PC_W-1:0]   link_data;
   logic              illegal_op;

   int checks = 0;
   int failures = 0;
   logic [PC_W-1:0] model_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   xfer_ctrl_unit #(.PC_W(PC_W), .DISP_W(DISP_W), .DATA_W(DATA_W)) u_xfer_ctrl_unit (
      .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .ctl_r(ctl_r), .ctl_x(ctl_x),
      .ctl_disp(ctl_disp), .cond_rd_idx(cond_rd_idx), .base_rd_idx(base_rd_idx),
      .cond_val(cond_val), .base_val(base_val), .fetch_pc(fetch_pc),
      .xfer_taken(xfer_taken), .link_we(link_we), .link_idx(link_idx),
      .link_data(link_data), .illegal_op(illegal_op)
   );

   // op, r, x, disp, cond, base, exp_taken, exp_illegal
   localparam logic [97:0] VEC [NVEC] = '{
      {4'h1, 4'h0, 4'h3, 20'h00100, 32'h0000_0000, 32'h0000_0020, 1'b1, 1'b0},
      {4'h2, 4'h1, 4'h0, 20'h00200, 32'h0000_0005, 32'h0000_0000, 1'b1, 1'b0},
      {4'h2, 4'h1, 4'h0, 20'h00300, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      {4'h3, 4'h2, 4'h0, 20'h00400, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 1'b0},
      {4'h3, 4'h2, 4'h0, 20'h00500, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      {4'h4, 4'h3, 4'h0, 20'h00600, 32'h0000_0000, 32'h0000_0002, 1'b1, 1'b0},
      {4'h4, 4'h3, 4'h0, 20'h00700, 32'h0000_0007, 32'h0000_0000, 1'b0, 1'b0},
      {4'h5, 4'h4, 4'h0, 20'h00800, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
      {4'h5, 4'h4, 4'h0, 20'h00900, 32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0},
      {4'h6, 4'h5, 4'h0, 20'h00A00, 32'h0000_0000, 32'h0000_0003, 1'b1, 1'b0},
      {4'h6, 4'h5, 4'h0, 20'h00B00, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b0},
      {4'h7, 4'h6, 4'h0, 20'h00C00, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
      {4'h7, 4'h6, 4'h0, 20'h00D00, 32'h8000_0000, 32'h0000_0004, 1'b1, 1'b0},
      {4'h0, 4'h2, 4'h7, 20'h01000, 32'h0000_0000, 32'h0000_0010, 1'b1, 1'b0},
      {4'h0, 4'h5, 4'h0, 20'h02000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
      {4'hA, 4'h0, 4'h0, 20'h03000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1},
      {4'h1, 4'h0, 4'h0, 20'hFFFFF, 32'h0000_0000, 32'h0000_0003, 1'b1, 1'b0},
      {4'h0, 4'h3, 4'h1, 20'h00001, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] op, input logic [3:0] r, input logic [3:0] x,
                         input logic [DISP_W-1:0] disp, input logic [31:0] cv,
                         input logic [31:0] bv, input bit e_take, input bit e_ill,
                         input string req);
      logic [PC_W-1:0] tgt;
      bit e_link;
      @(negedge clk);
      check(fetch_pc == model_pc, "R2 R3", "fetch_pc before op", 32'(fetch_pc), 32'(model_pc));
      ctl_op = op; ctl_r = r; ctl_x = x; ctl_disp = disp; cond_val = cv; base_val = bv;
      #1;
      e_link = (op == 4'h0) && (r[3:2] == 2'b00);
      check(xfer_taken == e_take, req, "xfer_taken", 32'(xfer_taken), 32'(e_take));
      check(illegal_op == e_ill, req, "illegal_op", 32'(illegal_op), 32'(e_ill));
      check(link_we == e_link, req, "link_we", 32'(link_we), 32'(e_link));
      if (e_link) begin
         check(link_idx == r[1:0], "R5", "link_idx", 32'(link_idx), 32'(r[1:0]));
         check(link_data == ((model_pc + 1) & PC_MASK), "R5", "link_data",
               32'(link_data), 32'((model_pc + 1) & PC_MASK));
      end
      tgt = (disp + bv[PC_W-1:0]) & PC_MASK;
      model_pc = e_take ? tgt : ((model_pc + 1) & PC_MASK);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state and suppressed first cycle
      ctl_op = 4'h0; ctl_r = 4'h1; base_val = 32'h40;
      repeat (3) @(negedge clk);
      check(fetch_pc == '0, "R1", "pc in reset", 32'(fetch_pc), 0);
      rst_n = 1'b1;
      #1;
      check(fetch_pc == '0, "R1", "pc after release", 32'(fetch_pc), 0);
      check(!xfer_taken && !link_we && !illegal_op, "R1", "first cycle quiet",
            {29'd0, xfer_taken, link_we, illegal_op}, 0);
      model_pc = 1;

      // Vector table: R3 R4 R5 R7
      for (int i = 0; i < NVEC; i++) begin
         logic [97:0] v;
         string tag;
         v = VEC[i];
         if (v[97:94] == 4'h0 && v[93:92] == 2'b00) tag = "R5";
         else if (v[0])                             tag = "R7";
         else if (v[97:94] == 4'h1)                 tag = "R3";
         else                                       tag = "R4";
         run_op(v[97:94], v[93:90], v[89:86], v[85:66], v[65:34], v[33:2],
                v[1], v[0], tag);
      end
      @(negedge clk);
      check(fetch_pc == model_pc, "R5", "pc after wrapping call", 32'(fetch_pc), 32'(model_pc));

      // R6: transfer in the delay slot overrides the first target
      run_op(4'h1, 4'h0, 4'h0, 20'h00400, 0, 0, 1'b1, 1'b0, "R6");
      run_op(4'h1, 4'h0, 4'h0, 20'h00800, 0, 0, 1'b1, 1'b0, "R6");
      @(negedge clk);
      check(fetch_pc == 20'h00800, "R6", "second target wins", 32'(fetch_pc), 32'h800);

      // R2: fall-through wraps at the top of the PC space
      run_op(4'h1, 4'h0, 4'h0, 20'hFFFFF, 0, 0, 1'b1, 1'b0, "R3");
      run_op(4'h4, 4'h0, 4'h0, 20'h00010, 5, 0, 1'b0, 1'b0, "R2");
      @(negedge clk);
      check(fetch_pc == '0, "R2", "wrap to zero", 32'(fetch_pc), 0);

      // R8: read index forwarding
      ctl_r = 4'hA; ctl_x = 4'h5;
      #1;
      check(cond_rd_idx == 4'hA, "R8", "cond_rd_idx", 32'(cond_rd_idx), 32'hA);
      check(base_rd_idx == 4'h5, "R8", "base_rd_idx", 32'(base_rd_idx), 32'h5);

      // R1: mid-run reset forces pc to zero at once
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(fetch_pc == '0, "R1", "async reset pc", 32'(fetch_pc), 0);
      @(negedge clk);
      rst_n = 1'b1;
      ctl_op = 4'h1;
      #1;
      check(!xfer_taken, "R1", "jump suppressed after reset", 32'(xfer_taken), 0);
      @(negedge clk);
      check(fetch_pc == 1, "R1", "pc steps to one", 32'(fetch_pc), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule